// File: doc/BRIEF.md
# Tile-Mode Background Pixel Generator

This block produces the background layer of a 256×192 tile display. The screen is a grid of 32 columns by 24 rows of 8×8 cells. For every cell, the block reads a one-byte pattern number from a name table held in video memory. It then reads the one pattern byte that covers the current pixel row. The pattern storage is split into three independent 2 KB banks, and the bank used depends on which vertical third of the screen the cell lies in. Each pixel bit then selects either the foreground or the background nibble of an 8-bit colour register.

A raster counter drives the block with one pixel position per clock. The block works at a fixed distance behind that counter. When the counter reaches the first pixel of a cell, the block issues the name read and then the pattern read on a synchronous memory port. The memory returns data one clock after it sees an address. The pattern byte is loaded into a shifter in time for the cell's first pixel. A display-active input blanks the output to the background colour.

Top module: `tile_bg_gen`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, colour_idx is 0 and mem_rd is 0.
- R2: A counter sample taken at clock edge t is a cell start when pix_x[2:0] == 0 and pix_y/8 < 24. For each cell start, after edge t the block drives mem_rd=1 with mem_addr = 0x3800 + (pix_y/8)*32 + pix_x/8.
- R3: The pattern read for a cell in cell rows 0–7 uses bank base 0x0000. Rows 8–15 use 0x0800, and rows 16–23 use 0x1000. The same pattern number therefore gives a different address in each third.
- R4: Two clocks after a name read, the block issues the pattern read with mem_addr = bank_base + name*8 + pix_y%8. Here name is the mem_rdata value returned one clock after the name address was presented.
- R5: A pattern bit of 1 selects colour_reg[7:4] and a bit of 0 selects colour_reg[3:0]. Bit 7 of the pattern byte is the leftmost pixel, at pix_x%8 == 0.
- R6: The colour for the counter value sampled at edge t appears on colour_idx after edge t+5. It uses the colour_reg value sampled at edge t+5.
- R7: When the active input sampled at edge t is 0, colour_idx after edge t+5 is colour_reg[3:0], whatever the pattern bit.
- R8: The block issues no reads except those in R2 and R4. Cells in rows 24 and above, and non-zero pixel phases, start no fetch.
- R9: At most one memory read is issued per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_x | input | 8 | Horizontal pixel position, advancing one per clock |
| pix_y | input | 8 | Vertical pixel line |
| active | input | 1 | High while the counter is inside the visible area |
| colour_reg | input | 8 | Foreground nibble in [7:4], background nibble in [3:0] |
| mem_rdata | input | 8 | Read data, valid one clock after the address |
| mem_addr | output | 14 | Video memory read address |
| mem_rd | output | 1 | Read strobe for mem_addr |
| colour_idx | output | 4 | Background colour index for the pixel |

## Verification
Some properties are checked by assertions on every clock. Name reads stay inside the 768-entry table and start only on a cell's first pixel. Pattern reads land in the bank that matches the third of the line sampled three clocks earlier, and their low address bits equal that line's row within the cell. No two reads are issued in the same clock. Blanked pixels show the background nibble. The bench's reference model is needed for three things. It checks that the right pattern byte reaches the right pixel in left-to-right bit order. It checks that banks with different contents really give different pictures for the same pattern number. It also checks that colour-register changes between pixels land exactly five edges after their counter sample.

// File: rtl/tbg_pkg.sv
package tbg_pkg;

    typedef logic [3:0] colour_t;

    function automatic colour_t fg_nibble(input logic [7:0] reg_val);
        return reg_val[7:4];
    endfunction

    function automatic colour_t bg_nibble(input logic [7:0] reg_val);
        return reg_val[3:0];
    endfunction

endpackage

// File: rtl/tbg_fetch.sv
module tbg_fetch #(
    parameter int COLS = 32,
    parameter int ROWS = 24,
    parameter int NBANKS = 3,
    parameter int XW = 8,
    parameter int YW = 8,
    parameter int DW = 8,
    parameter int AW = 14,
    parameter logic [AW-1:0] NAME_BASE = 14'h3800,
    parameter logic [AW-1:0] BANK_STRIDE = 14'h0800,
    parameter int STAGES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] pix_x,
    input  logic [YW-1:0] pix_y,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          name_rd,
    output logic          pat_rd,
    output logic          load
);

    localparam int CB = $clog2(DW);
    localparam int RW = YW - CB;
    localparam int CW = XW - CB;
    localparam int ROWS_PER_BANK = ROWS / NBANKS;
    localparam int BW = (NBANKS > 1) ? $clog2(NBANKS) : 1;
    localparam logic [AW-1:0] COLS_A = AW'(COLS);

    typedef struct packed {
        logic [STAGES-1:0] stg;
        logic [CB-1:0]     line;
        logic [BW-1:0]     bank;
        logic [AW-1:0]     addr;
    } fetch_t;

    fetch_t st_d, st_q;

    logic [RW-1:0] cell_row;
    logic [CW-1:0] cell_col;
    logic          start;

    always_comb begin
        cell_row = pix_y[YW-1:CB];
        cell_col = pix_x[XW-1:CB];
        // a pattern read in progress keeps the address register
        start    = (pix_x[CB-1:0] == '0) && (cell_row < RW'(ROWS)) && !st_q.stg[1];

        st_d     = st_q;
        st_d.stg = {st_q.stg[STAGES-2:0], start};
        if (st_q.stg[1]) begin
            st_d.addr = AW'(st_q.bank) * BANK_STRIDE + AW'({mem_rdata, st_q.line});
        end else if (start) begin
            st_d.line = pix_y[CB-1:0];
            st_d.bank = BW'(cell_row / RW'(ROWS_PER_BANK));
            st_d.addr = NAME_BASE + AW'(cell_row) * COLS_A + AW'(cell_col);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr = st_q.addr;
    assign name_rd  = st_q.stg[0];
    assign pat_rd   = st_q.stg[2];
    assign mem_rd   = st_q.stg[0] | st_q.stg[2];
    assign load     = st_q.stg[STAGES-1];

    // R8: name fetches begin only on the first pixel of a cell
    a_r8_cell_start: assert property (@(posedge clk) disable iff (!rst_n)
        name_rd |-> ($past(pix_x[CB-1:0]) == '0));

endmodule

// File: rtl/tbg_pixel.sv
module tbg_pixel
    import tbg_pkg::*;
#(
    parameter int DW = 8,
    parameter int ACT_D = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] pat_byte,
    input  logic          active,
    input  logic [7:0]    colour_reg,
    output colour_t       colour_idx
);

    typedef struct packed {
        logic [DW-1:0]    shift;
        logic [ACT_D-1:0] act;
        colour_t          col;
    } pix_t;

    pix_t px_d, px_q;

    always_comb begin
        px_d       = px_q;
        px_d.shift = load ? pat_byte : {px_q.shift[DW-2:0], 1'b0};
        px_d.act   = {px_q.act[ACT_D-2:0], active};
        if (px_q.act[ACT_D-1] && px_q.shift[DW-1]) begin
            px_d.col = fg_nibble(colour_reg);
        end else begin
            px_d.col = bg_nibble(colour_reg);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_q <= '0;
        end else begin
            px_q <= px_d;
        end
    end

    assign colour_idx = px_q.col;

    // R7: blanked pixel shows the background nibble
    a_r7_blank_bg: assert property (@(posedge clk) disable iff (!rst_n)
        !px_q.act[ACT_D-1] |=> (colour_idx == $past(colour_reg[3:0])));

endmodule

// File: rtl/tile_bg_gen.sv
module tile_bg_gen
    import tbg_pkg::*;
#(
    parameter int COLS = 32,
    parameter int ROWS = 24,
    parameter int NBANKS = 3,
    parameter int XW = 8,
    parameter int YW = 8,
    parameter int DW = 8,
    parameter int AW = 14,
    parameter logic [AW-1:0] NAME_BASE = 14'h3800,
    parameter logic [AW-1:0] BANK_STRIDE = 14'h0800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] pix_x,
    input  logic [YW-1:0] pix_y,
    input  logic          active,
    input  logic [7:0]    colour_reg,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic [3:0]    colour_idx
);

    localparam int CB = $clog2(DW);
    localparam int STAGES = 4;
    localparam int ACT_D = STAGES + 1;
    localparam int ROWS_PER_BANK = ROWS / NBANKS;
    localparam logic [AW-1:0] NAME_END = NAME_BASE + AW'(COLS * ROWS);

    logic name_rd;
    logic pat_rd;
    logic load;

    tbg_fetch #(
        .COLS(COLS), .ROWS(ROWS), .NBANKS(NBANKS), .XW(XW), .YW(YW), .DW(DW),
        .AW(AW), .NAME_BASE(NAME_BASE), .BANK_STRIDE(BANK_STRIDE), .STAGES(STAGES)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .name_rd(name_rd), .pat_rd(pat_rd), .load(load)
    );

    tbg_pixel #(
        .DW(DW), .ACT_D(ACT_D)
    ) u_pix (
        .clk(clk), .rst_n(rst_n), .load(load), .pat_byte(mem_rdata),
        .active(active), .colour_reg(colour_reg), .colour_idx(colour_idx)
    );

    // R9: never more than one read kind per clock
    a_r9_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({name_rd, pat_rd}));

    // R2: name reads stay inside the name table
    a_r2_name_window: assert property (@(posedge clk) disable iff (!rst_n)
        name_rd |-> ((mem_addr >= NAME_BASE) && (mem_addr < NAME_END)));

    // R3: bank of a pattern read follows the screen third of its line
    a_r3_bank_third: assert property (@(posedge clk) disable iff (!rst_n)
        pat_rd |-> ((mem_addr / BANK_STRIDE) ==
                    AW'((AW'($past(pix_y, 3)) >> CB) / AW'(ROWS_PER_BANK))));

    // R4: row within the pattern follows the sampled line
    a_r4_pat_row: assert property (@(posedge clk) disable iff (!rst_n)
        pat_rd |-> (mem_addr[CB-1:0] == $past(pix_y[CB-1:0], 3)));

endmodule

// File: tb/sim_tile_bg_gen.sv
module sim_tile_bg_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pix_x = '0;
    logic [7:0]  pix_y = '0;
    logic        active = 1'b0;
    logic [7:0]  colour_reg = '0;
    logic [7:0]  mem_rdata = '0;
    logic [13:0] mem_addr;
    logic        mem_rd;
    logic [3:0]  colour_idx;

    int vectors = 0;
    int fails = 0;
    int k = 0;
    int frame = 0;
    int unsigned seed = 32'h1234_5678;

    logic [7:0] hx [8];
    logic [7:0] hy [8];
    logic       ha [8];
    logic [7:0] hc [8];

    always #10 clk = ~clk;

    tile_bg_gen u0 (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
        .active(active), .colour_reg(colour_reg), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .colour_idx(colour_idx)
    );

    // memory contents are a pure function of address and frame
    function automatic logic [7:0] vram(input int a, input int f);
        int unsigned h;
        if (a >= 'h3800) begin
            h = (a - 'h3800) * 13 + f * 91 + ((a - 'h3800) >> 3);
            return h[7:0];
        end
        h = a * 1103515245 + 12345;
        return h[23:16] ^ a[7:0];
    endfunction

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= vram(int'(mem_addr), frame);
    end

    function automatic int rnd();
        seed = seed * 1664525 + 1013904223;
        return int'(seed >> 8);
    endfunction

    function automatic bit is_start(input logic [7:0] x, input logic [7:0] y);
        return (x[2:0] == 3'd0) && ((y >> 3) < 24);
    endfunction

    task automatic check_cycle();
        int i0, i2, i5, row, nm;
        logic        exp_rd;
        logic [13:0] exp_addr;
        logic [7:0]  pb;
        logic [3:0]  exp_col;
        string       tag;
        i0 = k & 7;
        exp_rd = 1'b0;
        exp_addr = '0;
        tag = "R8 R9";
        if (is_start(hx[i0], hy[i0])) begin
            exp_rd = 1'b1;
            exp_addr = 14'('h3800 + (hy[i0] >> 3) * 32 + (hx[i0] >> 3));
            tag = "R2";
        end else if (k >= 2) begin
            i2 = (k - 2) & 7;
            if (is_start(hx[i2], hy[i2])) begin
                row = hy[i2] >> 3;
                nm = vram('h3800 + row * 32 + (hx[i2] >> 3), frame);
                exp_rd = 1'b1;
                exp_addr = 14'((row / 8) * 'h800 + nm * 8 + hy[i2][2:0]);
                tag = "R3 R4";
            end
        end
        vectors++;
        if (mem_rd !== exp_rd || (exp_rd && mem_addr !== exp_addr)) begin
            fails++;
            $display("FAIL %s cycle %0d rd=%0b addr=%h expected rd=%0b addr=%h",
                     tag, k, mem_rd, mem_addr, exp_rd, exp_addr);
        end
        // colour: counter sample five edges back, colour register of this edge
        exp_col = hc[i0][3:0];
        tag = "R6 R7";
        if (k >= 5) begin
            i5 = (k - 5) & 7;
            if (ha[i5]) begin
                row = hy[i5] >> 3;
                nm = vram('h3800 + row * 32 + (hx[i5] >> 3), frame);
                pb = vram((row / 8) * 'h800 + nm * 8 + hy[i5][2:0], frame);
                exp_col = pb[7 - hx[i5][2:0]] ? hc[i0][7:4] : hc[i0][3:0];
                tag = "R3 R5 R6";
            end
        end
        vectors++;
        if (colour_idx !== exp_col) begin
            fails++;
            $display("FAIL %s cycle %0d colour_idx=%h expected %h",
                     tag, k, colour_idx, exp_col);
        end
    endtask

    task automatic step(input logic [7:0] x, input logic [7:0] y,
                        input logic a, input logic [7:0] c);
        pix_x = x; pix_y = y; active = a; colour_reg = c;
        hx[k & 7] = x; hy[k & 7] = y; ha[k & 7] = a; hc[k & 7] = c;
        @(posedge clk);
        @(negedge clk);
        check_cycle();
        k++;
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog expired at cycle %0d", k);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [7:0] col;
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            vectors++;
            if (colour_idx !== 4'd0 || mem_rd !== 1'b0) begin
                fails++;
                $display("FAIL R1 reset colour_idx=%h mem_rd=%0b expected 0 0",
                         colour_idx, mem_rd);
            end
        end
        rst_n = 1'b1;
        col = 8'hF0;
        for (int f = 0; f < 2; f++) begin
            frame = f;
            for (int ln = 0; ln < 196; ln++) begin
                col = 8'(rnd());
                for (int h = 0; h < 264; h++) begin
                    logic vis;
                    logic a;
                    vis = (ln < 192) && (h < 256);
                    // frame 0 blanks some pixels, frame 1 blanks whole stripes
                    if (f == 0) a = vis && ((rnd() % 11) != 0);
                    else a = vis && !((ln >= 60) && (ln < 70));
                    if (h % 37 == 5) col = 8'(rnd());
                    step(8'(h), 8'(ln), a, col);
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule